// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block walks a stream of instruction bytes, one per cycle, and finds where each instruction ends in a legacy variable-length CISC encoding. It accepts bytes on a valid/ready handshake and steps through the fields in their fixed order: prefix bytes, then one to three opcode bytes, then an optional addressing byte, an optional scale-index-base byte, a displacement and an immediate. One cycle after the last byte of an instruction it pulses `done_o` for one cycle. With that pulse it reports the total length and the number of bytes found in each field.

The opcode itself is not decoded here. When the final opcode byte is on the bus, the block sends that byte and the opcode map it belongs to out to an external class table. The table answers combinationally with whether an addressing byte follows and which immediate size class applies. Displacement size and the presence of a scale-index-base byte come from the addressing byte. The rules differ between 16-bit and 32-bit addressing, and an address-size prefix can flip the mode for a single instruction.

Top module: `ild_top`

## Requirements
- R1: Each of the bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3 seen before the opcode counts as one prefix byte, up to four per instruction.
- R2: A fifth prefix byte ends the instruction with `err_o`=1, `len_o`=5 and `pfx_cnt_o`=5. The next byte starts a new instruction.
- R3: A first opcode byte of 0x0F is followed by a second opcode byte. A 0x0F first byte followed by 0x38 or 0x3A is followed by a third opcode byte. `lk_map_o` reads 0 for the one-byte map, 1 after 0x0F, 2 after 0x0F 0x38 and 3 after 0x0F 0x3A. `lk_byte_o` mirrors the current byte.
- R4: The table answer is taken on the last opcode byte. `lk_modrm_i`=1 adds one addressing byte. `lk_imm_i` codes 0/1/2/3 give 0, 1, operand size (2 or 4) and 2 immediate bytes.
- R5: In 32-bit addressing, r/m (bits 2:0)=100 with mod (bits 7:6) other than 11 adds a scale-index-base byte. mod=01 adds 1 displacement byte, mod=10 adds 4, and mod=00 with r/m=101 adds 4.
- R6: When a scale-index-base byte is present with mod=00, its base field (bits 2:0) equal to 101 adds a 4-byte displacement, and any other base adds none.
- R7: In 16-bit addressing, mod=01 adds 1 displacement byte, mod=10 adds 2, and mod=00 with r/m=110 adds 2. No scale-index-base byte ever follows.
- R8: mod=11 adds neither a scale-index-base byte nor a displacement.
- R9: Prefix 0x67 inverts the addressing mode given by `addr32_dflt_i` for that instruction, and 0x66 inverts the operand size, which defaults to the same width. Repeating either prefix does not invert the mode back.
- R10: A 15-byte instruction completes normally. The 16th byte of an unfinished instruction ends it with `err_o`=1 and `len_o`=16.
- R11: `done_o` is high for exactly the cycle after the final byte is accepted. In that cycle `len_o` equals the sum of the field counts, and the next accepted byte starts a new instruction.
- R12: After reset `done_o`, `err_o`, `len_o` and all field counts are 0, and `ready_o` is 1.
- R13: While `valid_i` is low the byte lines are ignored and parsing state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte on `byte_i` is valid |
| byte_i | input | 8 | Instruction byte |
| ready_o | output | 1 | Byte accepted when valid |
| addr32_dflt_i | input | 1 | Default mode: 1 = 32-bit, 0 = 16-bit |
| lk_map_o | output | 2 | Opcode map of the current byte, for the class table |
| lk_byte_o | output | 8 | Opcode byte presented to the class table |
| lk_modrm_i | input | 1 | Table: an addressing byte follows |
| lk_imm_i | input | 2 | Table: immediate size class |
| done_o | output | 1 | One-cycle instruction-complete pulse |
| err_o | output | 1 | Instruction overlong (with `done_o`) |
| len_o | output | 5 | Total instruction length in bytes |
| pfx_cnt_o | output | 3 | Prefix byte count |
| op_cnt_o | output | 2 | Opcode byte count |
| modrm_o | output | 1 | Addressing byte present |
| sib_o | output | 1 | Scale-index-base byte present |
| disp_cnt_o | output | 3 | Displacement byte count |
| imm_cnt_o | output | 3 | Immediate byte count |

## Verification
The assertions take for granted that the class table answers combinationally and stays stable while a byte is held valid. They also assume that `addr32_dflt_i` changes only between instructions. The bench's table model is a pure function of the map and byte outputs. The bench changes the default mode only while `valid_i` is low and no instruction is open, and it sometimes puts idle cycles with junk bytes between the valid bytes to exercise the hold rule.

// File: rtl/ild_pkg.sv
package ild_pkg;
  typedef enum logic [2:0] {
    ST_PFX, ST_OP2, ST_OP3, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } ild_state_e;

  localparam logic [7:0] ESC_BYTE = 8'h0F;
  localparam logic [7:0] ESC3_A   = 8'h38;
  localparam logic [7:0] ESC3_B   = 8'h3A;

  // immediate class -> byte count
  function automatic logic [2:0] imm_size(input logic [1:0] code, input logic osz32);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return osz32 ? 3'd4 : 3'd2;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/ild_pfx_class.sv
module ild_pfx_class (
  input  logic [7:0] byte_i,
  output logic       is_pfx_o,
  output logic       is_asz_o,
  output logic       is_osz_o
);
  always_comb begin
    is_asz_o = (byte_i == 8'h67);
    is_osz_o = (byte_i == 8'h66);
    case (byte_i)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: is_pfx_o = 1'b1;
      default:                           is_pfx_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ild_addr_dec.sv
module ild_addr_dec (
  input  logic       addr32_i,
  input  logic [1:0] mod_i,      // mod of byte on the bus
  input  logic [2:0] rm_i,       // r/m or SIB base of byte on the bus
  input  logic [1:0] sib_mod_i,  // mod latched from the addressing byte
  output logic       need_sib_o,
  output logic [2:0] mdisp_o,
  output logic [2:0] sdisp_o
);
  always_comb begin
    need_sib_o = 1'b0;
    mdisp_o    = 3'd0;
    if (addr32_i) begin
      need_sib_o = (mod_i != 2'b11) && (rm_i == 3'b100);
      case (mod_i)
        2'b00:   mdisp_o = (rm_i == 3'b101) ? 3'd4 : 3'd0;
        2'b01:   mdisp_o = 3'd1;
        2'b10:   mdisp_o = 3'd4;
        default: mdisp_o = 3'd0;
      endcase
    end else begin
      case (mod_i)
        2'b00:   mdisp_o = (rm_i == 3'b110) ? 3'd2 : 3'd0;
        2'b01:   mdisp_o = 3'd1;
        2'b10:   mdisp_o = 3'd2;
        default: mdisp_o = 3'd0;
      endcase
    end
  end

  // displacement once the SIB byte is known (32-bit only)
  always_comb begin
    case (sib_mod_i)
      2'b00:   sdisp_o = (rm_i == 3'b101) ? 3'd4 : 3'd0;
      2'b01:   sdisp_o = 3'd1;
      2'b10:   sdisp_o = 3'd4;
      default: sdisp_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/ild_seq.sv
module ild_seq
  import ild_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int MAX_PFX = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 2),
  localparam int PFX_W  = $clog2(MAX_PFX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  input  logic             addr32_dflt_i,
  input  logic             is_pfx_i,
  input  logic             is_asz_i,
  input  logic             is_osz_i,
  input  logic             need_sib_i,
  input  logic [2:0]       mdisp_i,
  input  logic [2:0]       sdisp_i,
  input  logic             lk_modrm_i,
  input  logic [1:0]       lk_imm_i,
  output logic [1:0]       mod_o,
  output logic [1:0]       map_o,
  output logic             addr32_o,
  output logic             done_o,
  output logic             err_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PFX_W-1:0] pfx_cnt_o,
  output logic [1:0]       op_cnt_o,
  output logic             modrm_o,
  output logic             sib_o,
  output logic [2:0]       disp_cnt_o,
  output logic [2:0]       imm_cnt_o
);
  ild_state_e       st_q, st_d;
  logic [LEN_W-1:0] len_q, len_inc;
  logic [PFX_W-1:0] pfx_q, pfx_nx;
  logic [1:0]       op_q, op_nx, map_q, map_d, mod_q, mod_d;
  logic             mrm_q, sib_q, asz_q, asz_d, osz_q, osz_d;
  logic [2:0]       disp_q, disp_nx, imm_q, imm_nx;
  logic [2:0]       dleft_q, dleft_d, ileft_q, ileft_d, isz_q, isz_d;
  logic             inc_pfx, inc_op, inc_mrm, inc_sib, inc_disp, inc_imm;
  logic             look, tail, last, err, fire, osz32;
  logic [2:0]       tail_disp;

  assign fire     = valid_i;
  assign addr32_o = addr32_dflt_i ^ asz_q;
  assign osz32    = addr32_dflt_i ^ osz_d;
  assign mod_o    = mod_q;
  assign map_o    = map_q;

  always_comb begin
    st_d = st_q; map_d = map_q; mod_d = mod_q; asz_d = asz_q; osz_d = osz_q;
    dleft_d = dleft_q; ileft_d = ileft_q; isz_d = isz_q;
    inc_pfx = 1'b0; inc_op = 1'b0; inc_mrm = 1'b0; inc_sib = 1'b0;
    inc_disp = 1'b0; inc_imm = 1'b0;
    look = 1'b0; tail = 1'b0; tail_disp = 3'd0; last = 1'b0; err = 1'b0;
    case (st_q)
      ST_PFX: begin
        if (is_pfx_i) begin
          inc_pfx = 1'b1;
          asz_d   = asz_q | is_asz_i;
          osz_d   = osz_q | is_osz_i;
          if (pfx_q == PFX_W'(MAX_PFX)) err = 1'b1;
        end else begin
          inc_op = 1'b1;
          if (byte_i == ESC_BYTE) begin
            st_d  = ST_OP2;
            map_d = 2'd1;
          end else look = 1'b1;
        end
      end
      ST_OP2: begin
        inc_op = 1'b1;
        if (byte_i == ESC3_A) begin
          st_d = ST_OP3; map_d = 2'd2;
        end else if (byte_i == ESC3_B) begin
          st_d = ST_OP3; map_d = 2'd3;
        end else look = 1'b1;
      end
      ST_OP3: begin
        inc_op = 1'b1;
        look   = 1'b1;
      end
      ST_MODRM: begin
        inc_mrm = 1'b1;
        mod_d   = byte_i[7:6];
        if (need_sib_i) st_d = ST_SIB;
        else begin
          tail = 1'b1; tail_disp = mdisp_i;
        end
      end
      ST_SIB: begin
        inc_sib = 1'b1;
        tail = 1'b1; tail_disp = sdisp_i;
      end
      ST_DISP: begin
        inc_disp = 1'b1;
        dleft_d  = dleft_q - 3'd1;
        if (dleft_q == 3'd1) tail = 1'b1;
      end
      ST_IMM: begin
        inc_imm = 1'b1;
        ileft_d = ileft_q - 3'd1;
        if (ileft_q == 3'd1) last = 1'b1;
      end
      default: st_d = ST_PFX;
    endcase

    if (look) begin
      isz_d = imm_size(lk_imm_i, osz32);
      if (lk_modrm_i) st_d = ST_MODRM;
      else tail = 1'b1;
    end

    if (tail) begin
      if (tail_disp != 3'd0) begin
        dleft_d = tail_disp; st_d = ST_DISP;
      end else if (isz_d != 3'd0) begin
        ileft_d = isz_d; st_d = ST_IMM;
      end else last = 1'b1;
    end

    if (len_inc > LEN_W'(MAX_LEN)) err = 1'b1;
  end

  assign len_inc = len_q + LEN_W'(1);
  assign pfx_nx  = pfx_q + PFX_W'(inc_pfx);
  assign op_nx   = op_q + 2'(inc_op);
  assign disp_nx = disp_q + 3'(inc_disp);
  assign imm_nx  = imm_q + 3'(inc_imm);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_PFX; len_q <= '0; pfx_q <= '0; op_q <= '0; mrm_q <= 1'b0; sib_q <= 1'b0;
      disp_q <= '0; imm_q <= '0; map_q <= '0; mod_q <= '0; asz_q <= 1'b0; osz_q <= 1'b0;
      dleft_q <= '0; ileft_q <= '0; isz_q <= '0;
      done_o <= 1'b0; err_o <= 1'b0; len_o <= '0; pfx_cnt_o <= '0; op_cnt_o <= '0;
      modrm_o <= 1'b0; sib_o <= 1'b0; disp_cnt_o <= '0; imm_cnt_o <= '0;
    end else begin
      done_o <= fire && (last || err);
      if (fire) begin
        if (last || err) begin
          err_o      <= err;
          len_o      <= len_inc;
          pfx_cnt_o  <= pfx_nx;
          op_cnt_o   <= op_nx;
          modrm_o    <= mrm_q | inc_mrm;
          sib_o      <= sib_q | inc_sib;
          disp_cnt_o <= disp_nx;
          imm_cnt_o  <= imm_nx;
          st_q <= ST_PFX; len_q <= '0; pfx_q <= '0; op_q <= '0; mrm_q <= 1'b0;
          sib_q <= 1'b0; disp_q <= '0; imm_q <= '0; map_q <= '0; mod_q <= '0;
          asz_q <= 1'b0; osz_q <= 1'b0; dleft_q <= '0; ileft_q <= '0; isz_q <= '0;
        end else begin
          st_q <= st_d; len_q <= len_inc; pfx_q <= pfx_nx; op_q <= op_nx;
          mrm_q <= mrm_q | inc_mrm; sib_q <= sib_q | inc_sib;
          disp_q <= disp_nx; imm_q <= imm_nx; map_q <= map_d; mod_q <= mod_d;
          asz_q <= asz_d; osz_q <= osz_d; dleft_q <= dleft_d; ileft_q <= ileft_d;
          isz_q <= isz_d;
        end
      end
    end
  end

  // R2: open prefix count never passes the limit
  p_pfx_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfx_q <= PFX_W'(MAX_PFX));
  // R3: escape byte leads to second opcode byte
  p_esc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PFX && valid_i && !is_pfx_i && byte_i == ESC_BYTE && len_q < LEN_W'(MAX_LEN))
      |=> st_q == ST_OP2);
  // R5: SIB state is only entered from the addressing byte
  p_sib_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_SIB) |-> $past(st_q) == ST_MODRM);
  // R7: 16-bit addressing never asks for SIB
  p_no_sib16_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MODRM && valid_i && !addr32_o) |-> !need_sib_i);
  // R8: register form goes to neither SIB nor displacement
  p_reg_form_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MODRM && valid_i && byte_i[7:6] == 2'b11)
      |=> (st_q != ST_SIB && st_q != ST_DISP));
  // R13: idle cycles hold parse state
  p_idle_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(st_q) && $stable(len_q)));
endmodule

// File: rtl/ild_top.sv
module ild_top
  import ild_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int MAX_PFX = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 2),
  localparam int PFX_W  = $clog2(MAX_PFX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  output logic             ready_o,
  input  logic             addr32_dflt_i,
  output logic [1:0]       lk_map_o,
  output logic [7:0]       lk_byte_o,
  input  logic             lk_modrm_i,
  input  logic [1:0]       lk_imm_i,
  output logic             done_o,
  output logic             err_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PFX_W-1:0] pfx_cnt_o,
  output logic [1:0]       op_cnt_o,
  output logic             modrm_o,
  output logic             sib_o,
  output logic [2:0]       disp_cnt_o,
  output logic [2:0]       imm_cnt_o
);
  logic       is_pfx, is_asz, is_osz, need_sib, addr32;
  logic [2:0] mdisp, sdisp;
  logic [1:0] mod_q;

  assign ready_o   = 1'b1;
  assign lk_byte_o = byte_i;

  ild_pfx_class u_pfx (
    .byte_i  (byte_i),
    .is_pfx_o(is_pfx),
    .is_asz_o(is_asz),
    .is_osz_o(is_osz)
  );

  ild_addr_dec u_addr (
    .addr32_i  (addr32),
    .mod_i     (byte_i[7:6]),
    .rm_i      (byte_i[2:0]),
    .sib_mod_i (mod_q),
    .need_sib_o(need_sib),
    .mdisp_o   (mdisp),
    .sdisp_o   (sdisp)
  );

  ild_seq #(.MAX_LEN(MAX_LEN), .MAX_PFX(MAX_PFX)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .byte_i       (byte_i),
    .addr32_dflt_i(addr32_dflt_i),
    .is_pfx_i     (is_pfx),
    .is_asz_i     (is_asz),
    .is_osz_i     (is_osz),
    .need_sib_i   (need_sib),
    .mdisp_i      (mdisp),
    .sdisp_i      (sdisp),
    .lk_modrm_i   (lk_modrm_i),
    .lk_imm_i     (lk_imm_i),
    .mod_o        (mod_q),
    .map_o        (lk_map_o),
    .addr32_o     (addr32),
    .done_o       (done_o),
    .err_o        (err_o),
    .len_o        (len_o),
    .pfx_cnt_o    (pfx_cnt_o),
    .op_cnt_o     (op_cnt_o),
    .modrm_o      (modrm_o),
    .sib_o        (sib_o),
    .disp_cnt_o   (disp_cnt_o),
    .imm_cnt_o    (imm_cnt_o)
  );

  // R11: reported length is the sum of the field counts
  p_len_sum_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> len_o == LEN_W'(pfx_cnt_o) + LEN_W'(op_cnt_o) + LEN_W'(modrm_o)
                      + LEN_W'(sib_o) + LEN_W'(disp_cnt_o) + LEN_W'(imm_cnt_o));
  // R10: a clean completion never exceeds the limit
  p_len_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> len_o <= LEN_W'(MAX_LEN));
endmodule

// File: tb/tb_ild_top.sv
module tb_ild_top;
  typedef struct packed {
    logic       err;
    logic [4:0] len;
    logic [2:0] pfx;
    logic [1:0] op;
    logic       mrm;
    logic       sib;
    logic [2:0] disp;
    logic [2:0] imm;
  } exp_t;

  logic       clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, addr32_dflt_i = 1'b1;
  logic [7:0] byte_i = 8'h00;
  logic       ready_o, lk_modrm_i, done_o, err_o, modrm_o, sib_o;
  logic [1:0] lk_map_o, lk_imm_i, op_cnt_o;
  logic [7:0] lk_byte_o;
  logic [4:0] len_o;
  logic [2:0] pfx_cnt_o, disp_cnt_o, imm_cnt_o;

  int   n_chk = 0, n_err = 0;
  bit   gap_mode = 1'b0, finished = 1'b0;
  exp_t exp_q[$];
  string req_q[$];
  logic [7:0] bq[$];

  always #4 clk_i = ~clk_i;

  ild_top dut (.*);

  // class table model
  always_comb begin
    lk_modrm_i = 1'b0; lk_imm_i = 2'd0;
    case (lk_map_o)
      2'd0: case (lk_byte_o)
        8'h04: lk_imm_i = 2'd1;
        8'h05: lk_imm_i = 2'd2;
        8'h89: lk_modrm_i = 1'b1;
        8'h81: begin lk_modrm_i = 1'b1; lk_imm_i = 2'd2; end
        8'hC2: lk_imm_i = 2'd3;
        default: ;
      endcase
      2'd1: lk_modrm_i = 1'b1;
      2'd2: begin lk_modrm_i = 1'b1; if (lk_byte_o == 8'h80) lk_imm_i = 2'd2; end
      default: begin lk_modrm_i = 1'b1; lk_imm_i = 2'd1; end
    endcase
  end

  function automatic exp_t mk(input logic e, input int l, input int p, input int o,
                              input logic m, input logic s, input int d, input int i);
    exp_t x;
    x.err = e; x.len = 5'(l); x.pfx = 3'(p); x.op = 2'(o);
    x.mrm = m; x.sib = s; x.disp = 3'(d); x.imm = 3'(i);
    return x;
  endfunction

  task automatic check(input string req, input bit ok, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // driver: push expectation, then stream the bytes in bq
  task automatic insn(input string req, input exp_t e);
    exp_q.push_back(e);
    req_q.push_back(req);
    foreach (bq[k]) begin
      @(negedge clk_i);
      valid_i = 1'b1; byte_i = bq[k];
      if (gap_mode) begin
        @(negedge clk_i);
        valid_i = 1'b0; byte_i = 8'h0F;  // junk while idle (R13)
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0; byte_i = 8'hC4;
    bq.delete();
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      exp_t got;
      got = '{err_o, len_o, pfx_cnt_o, op_cnt_o, modrm_o, sib_o, disp_cnt_o, imm_cnt_o};
      if (exp_q.size() == 0) check("R11", 1'b0, $sformatf("unexpected done, got %h", got));
      else begin
        exp_t e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, got == e, $sformatf("actual %h expected %h", got, e));
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    check("watchdog", 1'b0, "actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12", done_o == 0 && err_o == 0 && len_o == 0 && pfx_cnt_o == 0 && op_cnt_o == 0
          && !modrm_o && !sib_o && disp_cnt_o == 0 && imm_cnt_o == 0,
          $sformatf("actual done=%b len=%0d expected all zero", done_o, len_o));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12", ready_o == 1'b1, $sformatf("actual ready=%b expected 1", ready_o));

    bq = '{8'h90};                            insn("R11", mk(0,1,0,1,0,0,0,0));
    bq = '{8'h04, 8'h12};                     insn("R4",  mk(0,2,0,1,0,0,0,1));
    bq = '{8'h05, 8'h1, 8'h2, 8'h3, 8'h4};    insn("R4",  mk(0,5,0,1,0,0,0,4));
    bq = '{8'h66, 8'h05, 8'h1, 8'h2};         insn("R9",  mk(0,4,1,1,0,0,0,2));
    bq = '{8'h66, 8'hC2, 8'h1, 8'h2};         insn("R4",  mk(0,4,1,1,0,0,0,2));
    bq = '{8'h89, 8'hC0};                     insn("R8",  mk(0,2,0,1,1,0,0,0));
    bq = '{8'h89, 8'h04, 8'h24};              insn("R6",  mk(0,3,0,1,1,1,0,0));
    gap_mode = 1'b1;
    bq = '{8'h89, 8'h04, 8'h25, 8'h1, 8'h2, 8'h3, 8'h4};
                                              insn("R6",  mk(0,7,0,1,1,1,4,0));
    bq = '{8'h89, 8'h44, 8'h24, 8'h08};       insn("R5",  mk(0,4,0,1,1,1,1,0));
    bq = '{8'h89, 8'h05, 8'h1, 8'h2, 8'h3, 8'h4};
                                              insn("R5",  mk(0,6,0,1,1,0,4,0));
    bq = '{8'h81, 8'h80, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7, 8'h8};
                                              insn("R5",  mk(0,10,0,1,1,0,4,4));
    gap_mode = 1'b0;
    bq = '{8'h0F, 8'hAF, 8'hC1};              insn("R3",  mk(0,3,0,2,1,0,0,0));
    bq = '{8'h0F, 8'h38, 8'h00, 8'hC1};       insn("R3",  mk(0,4,0,3,1,0,0,0));
    bq = '{8'h0F, 8'h3A, 8'h0F, 8'hC1, 8'h08}; insn("R3", mk(0,5,0,3,1,0,0,1));
    bq = '{8'h67, 8'h89, 8'h46, 8'h08};       insn("R7",  mk(0,4,1,1,1,0,1,0));
    bq = '{8'h67, 8'h89, 8'h06, 8'h1, 8'h2};  insn("R7",  mk(0,5,1,1,1,0,2,0));
    bq = '{8'h67, 8'h89, 8'h04};              insn("R7",  mk(0,3,1,1,1,0,0,0));

    repeat (2) @(negedge clk_i);
    addr32_dflt_i = 1'b0;
    bq = '{8'h89, 8'h04};                     insn("R7",  mk(0,2,0,1,1,0,0,0));
    bq = '{8'h89, 8'h84, 8'h1, 8'h2};         insn("R7",  mk(0,4,0,1,1,0,2,0));
    bq = '{8'h67, 8'h89, 8'h04, 8'h24};       insn("R9",  mk(0,4,1,1,1,1,0,0));
    bq = '{8'h67, 8'h67, 8'h89, 8'h04, 8'h24}; insn("R9", mk(0,5,2,1,1,1,0,0));
    bq = '{8'h05, 8'h1, 8'h2};                insn("R9",  mk(0,3,0,1,0,0,0,2));
    bq = '{8'h66, 8'h05, 8'h1, 8'h2, 8'h3, 8'h4}; insn("R9", mk(0,6,1,1,0,0,0,4));
    repeat (2) @(negedge clk_i);
    addr32_dflt_i = 1'b1;

    bq = '{8'hF0, 8'hF3, 8'h2E, 8'h26, 8'h90}; insn("R1", mk(0,5,4,1,0,0,0,0));
    bq = '{8'h36, 8'h64, 8'h65, 8'hF2, 8'h90}; insn("R1", mk(0,5,4,1,0,0,0,0));
    bq = '{8'h3E, 8'h90};                     insn("R1",  mk(0,2,1,1,0,0,0,0));
    bq = '{8'h26, 8'h26, 8'h26, 8'h26, 8'h26}; insn("R2", mk(1,5,5,0,0,0,0,0));
    bq = '{8'h90};                            insn("R2",  mk(0,1,0,1,0,0,0,0));
    bq = '{8'hF0, 8'h2E, 8'h3E, 8'hF3, 8'h81, 8'h84, 8'h24,
           8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7, 8'h8};
                                              insn("R10", mk(0,15,4,1,1,1,4,4));
    bq = '{8'hF0, 8'h2E, 8'h3E, 8'hF3, 8'h0F, 8'h38, 8'h80, 8'h84, 8'h24,
           8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7};
                                              insn("R10", mk(1,16,4,3,1,1,4,3));
    bq = '{8'h04, 8'h7F};                     insn("R11", mk(0,2,0,1,0,0,0,1));

    // R13: long idle with junk bytes, then a fresh instruction must start clean
    repeat (5) @(negedge clk_i) byte_i = 8'h66;
    check("R13", done_o == 1'b0, $sformatf("actual done=%b expected 0 while idle", done_o));
    bq = '{8'h89, 8'hC3};                     insn("R13", mk(0,2,0,1,1,0,0,0));

    repeat (4) @(negedge clk_i);
    check("R11", exp_q.size() == 0, $sformatf("actual pending=%0d expected 0", exp_q.size()));
    summary();
  end
endmodule